// File: doc/BRIEF.md
# Snooze Power-Down Controller

This block sits at the input side of a synchronous memory and manages its low-power standby state. A sleep request arrives asynchronously and is active high. It is synchronised into the clock domain. While it is in force, the block deselects the memory and keeps the command, address, write-data and byte-enable capture registers from taking anything new from the host. Command strobes are forced inactive. Address, data and byte enables keep the last values that were accepted.

When the request drops, sampling resumes only after a fixed recovery wait. Two status outputs report the sequence. One flag shows that the controller is in standby. A one-cycle pulse warns that a write or burst command had been accepted but was still outstanding when gating began. Such an access is not guaranteed to complete.

Top module: `snz_ctrl`

## Requirements
- R1: After reset, `inputs_blocked`, `snooze_active`, `access_dropped` and every command register output are 0.
- R2: While the controller is awake and not blocking, each rising edge copies `host_sel`, `host_wr`, `host_adv`, `host_addr`, `host_wdata` and `host_be` into the matching `cmd_*` outputs.
- R3: `sleep_req` passes through a two-flop synchroniser. `inputs_blocked` rises after the second rising edge following the request's rise. Host inputs at that second edge are still captured, and inputs at the third edge are not.
- R4: On every edge at which inputs are blocked, `cmd_sel`, `cmd_wr` and `cmd_adv` are cleared to 0, which deselects the memory.
- R5: On every edge at which inputs are blocked, `cmd_addr`, `cmd_wdata` and `cmd_be` hold their last accepted values, whatever the host drives.
- R6: `snooze_active` rises at the third edge after the request rises, after gating is already in effect. It stays high for the whole standby and recovery period and is never high while `inputs_blocked` is low.
- R7: At the edge where standby is entered, `access_dropped` pulses high for exactly one cycle if the last accepted command had `cmd_wr` or `cmd_adv` set. If the last accepted command was a plain read, it stays low.
- R8: After `sleep_req` falls, blocking lasts for the synchroniser delay, one edge to leave standby and RECOVER_CYC recovery edges (5 edges by default). `snooze_active` and `inputs_blocked` then fall together, and host inputs are captured again from the following edge.
- R9: If the request rises again during recovery, the controller goes back to standby without ever unblocking, and `access_dropped` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset |
| sleep_req | input | 1 | Asynchronous active-high standby request |
| host_sel | input | 1 | Host device select |
| host_wr | input | 1 | Host write command |
| host_adv | input | 1 | Host burst advance |
| host_addr | input | ADDR_W | Host address |
| host_wdata | input | DATA_W | Host write data |
| host_be | input | LANES | Host byte-lane enables |
| cmd_sel | output | 1 | Registered select to the memory |
| cmd_wr | output | 1 | Registered write command |
| cmd_adv | output | 1 | Registered burst advance |
| cmd_addr | output | ADDR_W | Registered address |
| cmd_wdata | output | DATA_W | Registered write data |
| cmd_be | output | LANES | Registered byte-lane enables |
| inputs_blocked | output | 1 | High while host inputs are gated |
| snooze_active | output | 1 | Standby status flag |
| access_dropped | output | 1 | One-cycle pulse: an outstanding access was cut off |

## Verification
A captured host value appears on `cmd_*` one edge after it is driven. Gating begins after the second edge of a request. `snooze_active` and any `access_dropped` pulse follow at the third edge, and the pulse is gone at the fourth. On exit, the controller unblocks at the fifth edge after release and captures again at the sixth. The bench drives inputs one nanosecond after an edge, counts edges from the moment it changes `sleep_req`, and samples each output one nanosecond after the exact edge where the value is due. It also checks the edge just before, so that early and late transitions are both caught.

// File: rtl/snz_pkg.sv
`timescale 1ns/1ps
package snz_pkg;

  typedef enum logic [1:0] {
    SNZ_AWAKE   = 2'd0,
    SNZ_ASLEEP  = 2'd1,
    SNZ_RECOVER = 2'd2
  } snz_state_e;

  // width of the recovery counter that counts 0 .. rec-1
  function automatic int snz_cnt_w(input int rec);
    return (rec > 1) ? $clog2(rec) : 1;
  endfunction

  // last count value of the recovery wait
  function automatic int snz_rec_last(input int rec);
    return (rec > 0) ? rec - 1 : 0;
  endfunction

  // edges from request release until sampling is unblocked
  function automatic int snz_exit_edges(input int stages, input int rec);
    return stages + 1 + rec;
  endfunction

endpackage

// File: rtl/snz_sync.sv
`timescale 1ns/1ps
module snz_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= async_in;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= 1'b0;
          else        chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/snz_seq.sv
`timescale 1ns/1ps
module snz_seq
  import snz_pkg::*;
#(
  parameter int RECOVER_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_sync,
  input  logic op_busy,
  output logic block_o,
  output logic standby_o,
  output logic dropped_o
);
  localparam int CW = snz_cnt_w(RECOVER_CYC);
  localparam logic [CW-1:0] LAST = CW'(snz_rec_last(RECOVER_CYC));

  snz_state_e      state_q;
  logic [CW-1:0]   cnt_q;
  logic            dropped_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= SNZ_AWAKE;
      cnt_q     <= '0;
      dropped_q <= 1'b0;
    end else begin
      dropped_q <= 1'b0;
      case (state_q)
        SNZ_AWAKE: begin
          if (req_sync) begin
            state_q   <= SNZ_ASLEEP;
            dropped_q <= op_busy;
          end
        end
        SNZ_ASLEEP: begin
          if (!req_sync) begin
            state_q <= SNZ_RECOVER;
            cnt_q   <= '0;
          end
        end
        SNZ_RECOVER: begin
          if (req_sync)           state_q <= SNZ_ASLEEP;
          else if (cnt_q == LAST) state_q <= SNZ_AWAKE;
          else                    cnt_q   <= cnt_q + 1'b1;
        end
        default: state_q <= SNZ_AWAKE;
      endcase
    end
  end

  // gating takes effect as soon as the synchronised request is seen
  assign block_o   = (state_q != SNZ_AWAKE) || req_sync;
  assign standby_o = (state_q != SNZ_AWAKE);
  assign dropped_o = dropped_q;
endmodule

// File: rtl/snz_capture.sv
`timescale 1ns/1ps
module snz_capture #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 36,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              block,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic              adv_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [LANES-1:0]  be_i,
  output logic              sel_q,
  output logic              wr_q,
  output logic              adv_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] data_q,
  output logic [LANES-1:0]  be_q
);
  localparam int LANE_W = DATA_W / LANES;

  // command strobes: cleared while blocked, which deselects the memory
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
      wr_q  <= 1'b0;
      adv_q <= 1'b0;
    end else begin
      sel_q <= sel_i & ~block;
      wr_q  <= wr_i  & ~block;
      adv_q <= adv_i & ~block;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      addr_q <= '0;
    else if (!block) addr_q <= addr_i;
  end

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          data_q[l*LANE_W +: LANE_W] <= '0;
          be_q[l]                    <= 1'b0;
        end else if (!block) begin
          data_q[l*LANE_W +: LANE_W] <= data_i[l*LANE_W +: LANE_W];
          be_q[l]                    <= be_i[l];
        end
      end
    end
  endgenerate
endmodule

// File: rtl/snz_ctrl.sv
`timescale 1ns/1ps
module snz_ctrl #(
  parameter int ADDR_W      = 18,
  parameter int DATA_W      = 36,
  parameter int LANES       = 4,
  parameter int SYNC_STAGES = 2,
  parameter int RECOVER_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep_req,
  input  logic              host_sel,
  input  logic              host_wr,
  input  logic              host_adv,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic [LANES-1:0]  host_be,
  output logic              cmd_sel,
  output logic              cmd_wr,
  output logic              cmd_adv,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_wdata,
  output logic [LANES-1:0]  cmd_be,
  output logic              inputs_blocked,
  output logic              snooze_active,
  output logic              access_dropped
);
  logic req_synced;
  logic op_busy;
  logic gate_on;

  snz_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (sleep_req),
    .sync_out (req_synced)
  );

  // an accepted write or burst step still sits in the command register
  assign op_busy = cmd_wr | cmd_adv;

  snz_seq #(.RECOVER_CYC(RECOVER_CYC)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_sync  (req_synced),
    .op_busy   (op_busy),
    .block_o   (gate_on),
    .standby_o (snooze_active),
    .dropped_o (access_dropped)
  );

  snz_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_cap (
    .clk    (clk),
    .rst_n  (rst_n),
    .block  (gate_on),
    .sel_i  (host_sel),
    .wr_i   (host_wr),
    .adv_i  (host_adv),
    .addr_i (host_addr),
    .data_i (host_wdata),
    .be_i   (host_be),
    .sel_q  (cmd_sel),
    .wr_q   (cmd_wr),
    .adv_q  (cmd_adv),
    .addr_q (cmd_addr),
    .data_q (cmd_wdata),
    .be_q   (cmd_be)
  );

  assign inputs_blocked = gate_on;
endmodule

// File: rtl/snz_ctrl_chk.sv
`timescale 1ns/1ps
module snz_ctrl_chk #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 36,
  parameter int LANES  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_synced,
  input logic              cmd_sel,
  input logic              cmd_wr,
  input logic              cmd_adv,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic [DATA_W-1:0] cmd_wdata,
  input logic [LANES-1:0]  cmd_be,
  input logic              inputs_blocked,
  input logic              snooze_active,
  input logic              access_dropped
);
  // R3: a synchronised request always gates the inputs
  a_r3_sync_gates: assert property (@(posedge clk) disable iff (!rst_n)
    req_synced |-> inputs_blocked);

  // R4: a blocked edge leaves the memory deselected
  a_r4_deselect_while_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    inputs_blocked |=> (!cmd_sel && !cmd_wr && !cmd_adv));

  // R5: address, data and lanes hold across a blocked edge
  a_r5_hold_while_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    inputs_blocked |=> ($stable(cmd_addr) && $stable(cmd_wdata) && $stable(cmd_be)));

  // R6: standby status never shows while inputs are open
  a_r6_status_needs_block: assert property (@(posedge clk) disable iff (!rst_n)
    snooze_active |-> inputs_blocked);

  // R7: the dropped-access pulse lasts one cycle
  a_r7_drop_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    access_dropped |=> !access_dropped);

  // R7: the pulse only accompanies entry into standby
  a_r7_drop_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
    access_dropped |-> $rose(snooze_active));

  // R8: status and gating release together
  a_r8_release_together: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(snooze_active) |-> !inputs_blocked);
endmodule

bind snz_ctrl snz_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_synced     (req_synced),
  .cmd_sel        (cmd_sel),
  .cmd_wr         (cmd_wr),
  .cmd_adv        (cmd_adv),
  .cmd_addr       (cmd_addr),
  .cmd_wdata      (cmd_wdata),
  .cmd_be         (cmd_be),
  .inputs_blocked (inputs_blocked),
  .snooze_active  (snooze_active),
  .access_dropped (access_dropped)
);

// File: tb/snz_ctrl_tb.sv
`timescale 1ns/1ps
module snz_ctrl_tb_top;
  localparam int AW = 18;
  localparam int DW = 36;
  localparam int LN = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sleep_req = 1'b0;
  logic          host_sel = 1'b0, host_wr = 1'b0, host_adv = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [DW-1:0] host_wdata = '0;
  logic [LN-1:0] host_be = '0;
  logic          cmd_sel, cmd_wr, cmd_adv;
  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] cmd_wdata;
  logic [LN-1:0] cmd_be;
  logic          inputs_blocked, snooze_active, access_dropped;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  snz_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req),
    .host_sel(host_sel), .host_wr(host_wr), .host_adv(host_adv),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_be(host_be),
    .cmd_sel(cmd_sel), .cmd_wr(cmd_wr), .cmd_adv(cmd_adv),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_be(cmd_be),
    .inputs_blocked(inputs_blocked), .snooze_active(snooze_active),
    .access_dropped(access_dropped)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // advance n rising edges, then settle 1 ns past the last one
  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic drive(input logic s, input logic w, input logic a,
                       input logic [AW-1:0] ad, input logic [DW-1:0] d, input logic [LN-1:0] b);
    host_sel = s; host_wr = w; host_adv = a;
    host_addr = ad; host_wdata = d; host_be = b;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    drive(1'b1, 1'b1, 1'b1, 18'h3ffff, 36'hfffffffff, 4'hf);
    tick(3);
    check("R1 blocked", inputs_blocked, 0);
    check("R1 snooze", snooze_active, 0);
    check("R1 dropped", access_dropped, 0);
    check("R1 cmd_sel", cmd_sel, 0);
    check("R1 cmd_addr", cmd_addr, 0);
    check("R1 cmd_wdata", cmd_wdata, 0);
    rst_n = 1'b1;
    drive(1'b0, 1'b0, 1'b0, '0, '0, '0);
    tick(1);
  endtask

  task automatic t_capture;
    drive(1'b1, 1'b1, 1'b0, 18'h12345, 36'h9abcdef01, 4'b1010);
    tick(1);
    check("R2 sel", cmd_sel, 1);
    check("R2 wr", cmd_wr, 1);
    check("R2 adv", cmd_adv, 0);
    check("R2 addr", cmd_addr, 64'h12345);
    check("R2 data", cmd_wdata, 64'h9abcdef01);
    check("R2 be", cmd_be, 64'ha);
    drive(1'b1, 1'b0, 1'b1, 18'h00abc, 36'h123456789, 4'b0101);
    tick(1);
    check("R2 wr read", cmd_wr, 0);
    check("R2 adv set", cmd_adv, 1);
    check("R2 addr 2", cmd_addr, 64'h00abc);
    check("R2 be 2", cmd_be, 64'h5);
  endtask

  // request standby; last command before gating is (w, a)
  task automatic t_enter(input logic w, input logic a, input logic exp_drop);
    drive(1'b1, w, a, 18'h00111, 36'h111111111, 4'h3);
    sleep_req = 1'b1;
    tick(1);  // edge 1
    check("R3 open after edge 1", inputs_blocked, 0);
    check("R2 addr edge 1", cmd_addr, 64'h00111);
    drive(1'b1, w, a, 18'h00222, 36'h222222222, 4'hc);
    tick(1);  // edge 2
    check("R3 blocked after edge 2", inputs_blocked, 1);
    check("R3 edge 2 captured", cmd_addr, 64'h00222);
    check("R6 snooze not yet", snooze_active, 0);
    check("R7 no early drop", access_dropped, 0);
    drive(1'b1, 1'b1, 1'b1, 18'h00333, 36'h333333333, 4'hf);
    tick(1);  // edge 3
    check("R4 sel cleared", cmd_sel, 0);
    check("R4 wr cleared", cmd_wr, 0);
    check("R4 adv cleared", cmd_adv, 0);
    check("R5 addr held", cmd_addr, 64'h00222);
    check("R5 data held", cmd_wdata, 64'h222222222);
    check("R5 be held", cmd_be, 64'hc);
    check("R6 snooze on edge 3", snooze_active, 1);
    check("R7 drop pulse", access_dropped, {63'd0, exp_drop});
    drive(1'b1, 1'b1, 1'b0, 18'h00444, 36'h444444444, 4'h1);
    tick(1);  // edge 4
    check("R7 pulse ended", access_dropped, 0);
    check("R6 snooze stays", snooze_active, 1);
    check("R5 addr still held", cmd_addr, 64'h00222);
    check("R4 sel still low", cmd_sel, 0);
  endtask

  task automatic t_exit;
    sleep_req = 1'b0;
    drive(1'b1, 1'b0, 1'b0, 18'h00555, 36'h555555555, 4'h6);
    tick(4);  // edges 1..4
    check("R8 blocked at edge 4", inputs_blocked, 1);
    check("R8 snooze at edge 4", snooze_active, 1);
    check("R4 sel low in recovery", cmd_sel, 0);
    tick(1);  // edge 5
    check("R8 unblocked at edge 5", inputs_blocked, 0);
    check("R8 snooze off at edge 5", snooze_active, 0);
    check("R5 addr held to edge 5", cmd_addr, 64'h00222);
    tick(1);  // edge 6
    check("R8 sel captured again", cmd_sel, 1);
    check("R8 addr captured again", cmd_addr, 64'h00555);
    check("R8 be captured again", cmd_be, 64'h6);
  endtask

  task automatic t_rerequest;
    sleep_req = 1'b0;
    tick(2);
    sleep_req = 1'b1;  // reaches the synchroniser output during recovery
    for (int e = 3; e <= 8; e++) begin
      tick(1);
      check("R9 still blocked", inputs_blocked, 1);
      check("R9 still snoozing", snooze_active, 1);
      check("R9 no drop", access_dropped, 0);
    end
  endtask

  initial begin
    t_reset;
    t_capture;
    t_enter(1'b1, 1'b0, 1'b1);  // write outstanding
    t_exit;
    t_enter(1'b0, 1'b1, 1'b1);  // burst step outstanding
    t_exit;
    t_enter(1'b0, 1'b0, 1'b0);  // plain read
    t_rerequest;
    t_exit;
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule